// File: doc/BRIEF.md
# Pipelined Function Unit Bus Slave

This block connects a fixed-latency pipelined compute unit to an AHB-Lite style bus through a single data register. Software starts a computation by writing an operand to that register. It collects the result by reading the same register. Results leave the pipeline and wait in a four-entry result queue until they are read. Reads come back in the same order as the writes were made.

Software needs no knowledge of the pipeline's depth. When a read arrives while the queue is empty and an operand is still in the pipeline, the read's data phase is held with `hreadyout` low until the result lands in the queue. A counter of outstanding operands covers operands in the pipeline plus results in the queue. A write that would push this counter past the queue capacity is held, so no result is ever lost. A read with nothing outstanding completes at once and returns zero.

The compute unit is modelled as `LAT` register stages. It applies a fixed transform: rotate the 32-bit operand left by 5 bits, then XOR it with 0x5A5AA5A5.

Top module: `acc_bus_wrap`

## Requirements
- R1: For two cycles after `hresetn` rises, the block stays in its reset state. After that, `hreadyout` is 1, `hrdata` is 0, `hresp` is 0 (OKAY) and no result is outstanding.
- R2: A transfer is taken when `hsel`=1, `htrans[1]`=1 and `hreadyout`=1. `hwrite`=1 makes it a write, and its operand is taken from `hwdata` in the following (data) cycle. A later read returns the operand rotated left by 5 bits and XORed with 0x5A5AA5A5.
- R3: Results are returned in the order in which their writes were made.
- R4: With LAT=3, take a read issued right after a single write with nothing else outstanding. Its data phase is held with `hreadyout` low for exactly 3 cycles. The data is returned 5 cycles after the write's address cycle, which is 6 cycles counting both ends.
- R5: A read issued with no operand outstanding completes without wait states, with `hrdata`=0 and `hresp`=0.
- R6: Groups of four back-to-back writes, each followed by four back-to-back reads, run with no wait state. The sustained rate is two cycles per result, and a result may enter the queue in the same cycle another result leaves it.
- R7: A write whose data phase arrives while four results are outstanding is held with `hreadyout` low, and the held operand is not taken.
- R8: Cycles with `hsel`=0 or with `htrans[1]`=0 start no transfer, and no result is queued for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type; bit 1 set means an active transfer |
| hwrite | input | 1 | 1 = write, 0 = read |
| hwdata | input | DW | Write data, valid in the data phase |
| hreadyout | output | 1 | Low holds the current data phase |
| hrdata | output | DW | Read data; zero when no result is returned |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
The function unit can deliver a result into the queue in the same cycle that a read removes the previous result from it. The queue then has to keep its level while it both writes one slot and frees another. The bench provokes this with groups of four writes followed by four reads. In that pattern each read falls exactly on the cycle after its result arrives. The bench judges the result by requiring the whole run to complete in eight cycles per group with no wait state, and by checking every returned value in write order against its scoreboard.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int DATA_W_DEF = 32;
  localparam int ROT_DEF = 5;
  localparam logic [31:0] KEY_DEF = 32'h5A5A_A5A5;

  // bus data-phase kind
  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2
  } phase_e;
endpackage

// File: rtl/acc_fu_pipe.sv
module acc_fu_pipe #(
  parameter int DW = 32,
  parameter int LAT = 3,
  parameter int ROT = 5,
  parameter logic [DW-1:0] KEY = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [DW-1:0] in_dat,
  output logic          out_vld,
  output logic [DW-1:0] out_dat,
  output logic [LAT-1:0] vld_vec
);
  logic [LAT-1:0] vld_q, vld_d;

  function automatic logic [DW-1:0] xform(input logic [DW-1:0] x);
    return ((x << ROT) | (x >> (DW - ROT))) ^ KEY;
  endfunction

  always_comb begin
    vld_d[0] = in_vld;
    for (int i = 1; i < LAT; i++) vld_d[i] = vld_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  genvar g;
  for (g = 0; g < LAT; g++) begin : g_st
    logic [DW-1:0] d_q;
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (in_vld) d_q <= xform(in_dat);
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (vld_q[g-1]) d_q <= g_st[g-1].d_q;
      end
    end
  end

  assign out_vld = vld_q[LAT-1];
  assign out_dat = g_st[LAT-1].d_q;
  assign vld_vec = vld_q;
endmodule

// File: rtl/acc_res_fifo.sv
module acc_res_fifo #(
  parameter int DW = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_dat,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic [$clog2(DEPTH+1)-1:0] lvl
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_d  = push ? step(wr_q) : wr_q;
    rd_d  = pop  ? step(rd_q) : rd_q;
    lvl_d = lvl_q + LW'(push) - LW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_dat;
  end

  assign head  = mem[rd_q];
  assign empty = (lvl_q == '0);
  assign lvl   = lvl_q;
endmodule

// File: rtl/acc_bus_wrap.sv
module acc_bus_wrap #(
  parameter int DW = acc_pkg::DATA_W_DEF,
  parameter int DEPTH = 4,
  parameter int LAT = 3,
  parameter int ROT = acc_pkg::ROT_DEF,
  parameter logic [DW-1:0] KEY = DW'(acc_pkg::KEY_DEF)
) (
  input  logic          hclk,
  input  logic          hresetn,
  input  logic          hsel,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic [DW-1:0] hwdata,
  output logic          hreadyout,
  output logic [DW-1:0] hrdata,
  output logic          hresp
);
  import acc_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) rs_q <= '0;
    else          rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          ph_wr, ph_rd, wr_ok, rd_pop, rd_wait, wr_hold, take;
  logic          fu_out_vld, fifo_empty;
  logic [DW-1:0] fu_out_dat, fifo_head;
  logic [LAT-1:0] fu_vld;
  logic [CW-1:0] fifo_lvl;
  logic          tr_unused;

  assign tr_unused = htrans[0];
  assign ph_wr = (ph_q == PH_WR);
  assign ph_rd = (ph_q == PH_RD);

  always_comb begin
    wr_ok   = ph_wr && (cnt < CW'(DEPTH));
    wr_hold = ph_wr && !wr_ok;
    rd_pop  = ph_rd && !fifo_empty;
    rd_wait = ph_rd && fifo_empty && (cnt != '0);
    hreadyout = !(wr_hold || rd_wait);
    take    = hsel && htrans[1] && hreadyout;
    if (!hreadyout) ph_d = ph_q;
    else if (take)  ph_d = hwrite ? PH_WR : PH_RD;
    else            ph_d = PH_NONE;
    cnt_d = cnt + CW'(wr_ok) - CW'(rd_pop);
  end

  always_ff @(posedge hclk or negedge rst_s) begin
    if (!rst_s) begin
      ph_q <= PH_NONE;
      cnt  <= '0;
    end else begin
      ph_q <= ph_d;
      cnt  <= cnt_d;
    end
  end

  acc_fu_pipe #(.DW(DW), .LAT(LAT), .ROT(ROT), .KEY(KEY)) u_fu (
    .clk(hclk), .rst_n(rst_s), .in_vld(wr_ok), .in_dat(hwdata),
    .out_vld(fu_out_vld), .out_dat(fu_out_dat), .vld_vec(fu_vld)
  );

  acc_res_fifo #(.DW(DW), .DEPTH(DEPTH)) u_q (
    .clk(hclk), .rst_n(rst_s), .push(fu_out_vld), .push_dat(fu_out_dat),
    .pop(rd_pop), .head(fifo_head), .empty(fifo_empty), .lvl(fifo_lvl)
  );

  assign hrdata = rd_pop ? fifo_head : '0;
  assign hresp  = 1'b0;
endmodule

// File: rtl/acc_bus_wrap_chk.sv
module acc_bus_wrap_chk #(
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int LAT = 3,
  parameter int CW = 3
) (
  input logic           hclk,
  input logic           rst_s,
  input logic           hsel,
  input logic [1:0]     htrans,
  input logic           hreadyout,
  input logic [DW-1:0]  hrdata,
  input logic           hresp,
  input logic           ph_wr,
  input logic           ph_rd,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  fifo_lvl,
  input logic [LAT-1:0] fu_vld,
  input logic           fu_out_vld,
  input logic           rd_pop
);
  // R7
  tally_match_chk: assert property (@(posedge hclk) disable iff (!rst_s)
    int'(cnt) == int'(fifo_lvl) + $countones(fu_vld));

  // R5
  zero_read_chk: assert property (@(posedge hclk) disable iff (!rst_s)
    (ph_rd && cnt == '0) |-> (hreadyout && hrdata == '0 && !hresp));

  // R4
  read_wait_chk: assert property (@(posedge hclk) disable iff (!rst_s)
    (ph_rd && !hreadyout) |-> (fifo_lvl == '0 && cnt != '0));

  // R6
  swap_level_chk: assert property (@(posedge hclk) disable iff (!rst_s)
    (fu_out_vld && rd_pop) |=> $stable(fifo_lvl));

  // R7
  write_hold_chk: assert property (@(posedge hclk) disable iff (!rst_s)
    (ph_wr && !hreadyout) |=> (cnt == $past(cnt)));

  // R8
  idle_none_chk: assert property (@(posedge hclk) disable iff (!rst_s)
    (hreadyout && !(hsel && htrans[1])) |=> (!ph_wr && !ph_rd));
endmodule

bind acc_bus_wrap acc_bus_wrap_chk #(.DW(DW), .DEPTH(DEPTH), .LAT(LAT), .CW(CW)) u_chk (
  .hclk(hclk), .rst_s(rst_s), .hsel(hsel), .htrans(htrans),
  .hreadyout(hreadyout), .hrdata(hrdata), .hresp(hresp),
  .ph_wr(ph_wr), .ph_rd(ph_rd), .cnt(cnt), .fifo_lvl(fifo_lvl),
  .fu_vld(fu_vld), .fu_out_vld(fu_out_vld), .rd_pop(rd_pop)
);

// File: tb/acc_bus_wrap_test.sv
module acc_bus_wrap_test;
  localparam int CLK_PER = 10;

  logic        hclk, hresetn, hsel, hwrite;
  logic [1:0]  htrans;
  logic [31:0] hwdata;
  logic        hreadyout, hresp;
  logic [31:0] hrdata;

  int total = 0, bad = 0, tick = 0;
  int stall_cnt = 0, done_tick = 0, acc_tick = 0;
  bit mon_rd = 0, pend_wr = 0;
  logic [31:0] pend_d = '0;
  logic [31:0] expq [$];
  string cur_req = "R2";

  acc_bus_wrap uut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hreadyout(hreadyout),
    .hrdata(hrdata), .hresp(hresp)
  );

  initial hclk = 0;
  always #(CLK_PER/2) hclk = ~hclk;
  always @(posedge hclk) tick <= tick + 1;

  function automatic logic [31:0] model(input logic [31:0] x);
    return {x[26:0], x[31:27]} ^ 32'h5A5A_A5A5;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard
  always @(negedge hclk) begin
    #1;
    if (mon_rd) begin
      if (!hreadyout) stall_cnt++;
      else begin
        logic [31:0] e;
        e = (expq.size() != 0) ? expq.pop_front() : 32'h0;
        check(hrdata == e, cur_req, hrdata, e);
        done_tick = tick;
      end
    end
  end

  // one bus cycle, called at a falling edge
  task automatic cyc(input bit sel, input logic [1:0] tr, input bit wr,
                     input logic [31:0] d, output bit rdy);
    hsel = sel; htrans = tr; hwrite = wr;
    hwdata = pend_wr ? pend_d : 32'h0;
    #2;
    rdy = hreadyout;
    if (rdy) begin
      if (sel && tr[1]) begin
        pend_wr = wr; mon_rd = !wr; pend_d = d; acc_tick = tick;
        if (wr) expq.push_back(model(d));
      end else begin
        pend_wr = 0; mon_rd = 0;
      end
    end
    @(negedge hclk);
  endtask

  task automatic do_op(input bit wr, input logic [31:0] d);
    bit r;
    do cyc(1, 2'b10, wr, d, r); while (!r);
  endtask

  task automatic idle(input int n);
    bit r;
    repeat (n) cyc(0, 2'b00, 0, 32'h0, r);
  endtask

  task automatic do_reset();
    hresetn = 0; hsel = 0; htrans = 2'b00; hwrite = 0; hwdata = '0;
    expq.delete(); pend_wr = 0; mon_rd = 0;
    repeat (3) @(negedge hclk);
    hresetn = 1;
    repeat (3) @(negedge hclk);
  endtask

  initial begin
    repeat (50000) @(posedge hclk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=done", tick);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tw;
    bit r;
    hresetn = 0; hsel = 0; htrans = 2'b00; hwrite = 0; hwdata = '0;
    @(negedge hclk);
    do_reset();
    #2;
    // R1 reset state
    check(hreadyout == 1'b1, "R1", 32'(hreadyout), 32'h1);
    check(hrdata == 32'h0, "R1", hrdata, 32'h0);
    check(hresp == 1'b0, "R1", 32'(hresp), 32'h0);
    @(negedge hclk);

    // R5 read with nothing outstanding
    cur_req = "R5"; stall_cnt = 0;
    do_op(0, 32'h0); idle(2);
    check(stall_cnt == 0, "R5", 32'(stall_cnt), 32'h0);
    check(hresp == 1'b0, "R5", 32'(hresp), 32'h0);

    // R2 / R4 single operation latency
    cur_req = "R2";
    do_op(1, 32'h1234_5678); tw = acc_tick; stall_cnt = 0;
    do_op(0, 32'h0); idle(6);
    check(stall_cnt == 3, "R4", 32'(stall_cnt), 32'h3);
    check(done_tick - tw == 5, "R4", 32'(done_tick - tw), 32'h5);
    cur_req = "R2";
    do_op(1, 32'h8000_0001); do_op(0, 32'h0); idle(6);

    // R6 / R3 streaming groups
    cur_req = "R3"; stall_cnt = 0;
    for (int g = 0; g < 3; g++) begin
      for (int k = 0; k < 4; k++) begin
        do_op(1, 32'hA000_0000 + 32'(g * 16 + k * 3 + 1));
        if (g == 0 && k == 0) tw = acc_tick;
      end
      for (int k = 0; k < 4; k++) do_op(0, 32'h0);
    end
    idle(3);
    check(stall_cnt == 0, "R6", 32'(stall_cnt), 32'h0);
    check(done_tick - tw == 24, "R6", 32'(done_tick - tw), 32'd24);

    // R3 interleaved write/read
    cur_req = "R3";
    for (int k = 0; k < 4; k++) begin
      do_op(1, 32'hFFFF_0000 ^ 32'(k * 977));
      do_op(0, 32'h0);
    end
    idle(6);

    // R8 idle and deselected cycles ignored
    cur_req = "R8";
    cyc(1, 2'b00, 1, 32'hDEAD_BEEF, r);
    cyc(0, 2'b10, 1, 32'hCAFE_F00D, r);
    idle(8);
    stall_cnt = 0;
    do_op(0, 32'h0); idle(2);
    check(stall_cnt == 0, "R8", 32'(stall_cnt), 32'h0);

    // R7 write held while four results outstanding
    cur_req = "R7";
    for (int k = 0; k < 4; k++) do_op(1, 32'(k + 7));
    idle(6);
    do_op(1, 32'h5555_5555);
    begin
      int lows = 0;
      for (int k = 0; k < 8; k++) begin
        cyc(0, 2'b00, 0, 32'h0, r);
        if (!r) lows++;
      end
      check(lows == 8, "R7", 32'(lows), 32'h8);
    end
    do_reset();
    #2;
    check(hreadyout == 1'b1, "R1", 32'(hreadyout), 32'h1);
    @(negedge hclk);
    cur_req = "R2";
    do_op(1, 32'h0F0F_1234); do_op(0, 32'h0); idle(6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule